// File: doc/BRIEF.md
# Privileged Control Register Unit

This block holds the processor status word and the supervisor-level control registers: the vector table base, the two alternate function-code registers, the user and supervisor translation root pointers, the translation control word and a bank of transparent-translation window registers. Every register access passes through one privilege check. The check uses the current privilege bit. A supervisor-only register touched from user mode is left unchanged and reads as zero. The access also raises a one-cycle violation pulse.

The status word is split into two bytes. User code may read and write the low condition-code byte. Supervisor code owns the upper system byte. The block also forms the exception vector fetch address from the table base and a vector number. It selects the translation root pointer from the supervisor bit of the access function code, and it exports the page-size choice of the translation control word.

Top module: `priv_ctl_regs`

## Requirements
- R1: The status word is 16 bits: bits 15:8 are the system byte and bits 7:0 the condition-code byte. Select code 1 reads or writes only the condition-code byte in either mode. Select code 0 gives supervisor code the full word. Read data is zero-extended to 32 bits.
- R2: A user-mode write to select code 0 changes bits 7:0 only, and bits 15:8 keep their value. A user-mode read of select code 0 returns bits 15:8 as zero. Neither access raises a violation.
- R3: Select codes 2 (vector base), 3 (source function code), 4 (destination function code), 5 (user root), 6 (supervisor root), 7 (translation control) and 8 to 11 (two instruction and two data transparent windows) are supervisor-only. A user-mode write to one of them leaves it unchanged, and a user-mode read of one of them returns zero.
- R4: Each user-mode read or write of a supervisor-only register drives `priv_viol` high in the cycle after the access, for that one cycle only. No other access raises it.
- R5: `vec_addr` equals the vector base plus the vector number times four, and it follows both inputs combinationally.
- R6: `root_ptr` shows the user root pointer when `fc_sup` is 0 and the supervisor root pointer when it is 1.
- R7: The source and destination function-code registers keep only write-data bits 2:0. They read back zero-extended.
- R8: In the translation control word, bit 15 is translation enable and bit 14 is page size (1 = 8 KB, 0 = 4 KB). All other bits read as zero. `page_8k` follows bit 14.
- R9: After reset the status word is 0x2700 (supervisor, interrupt level 7). The vector base, translation control word, function codes, root pointers and windows are zero, and `rd_data` and `priv_viol` are low.
- R10: `rd_data` is registered. It takes the read result one cycle after `rd_en`, using the register value from before any write in the same cycle, and it holds when no read is made. Select codes 12 to 15 read as zero, ignore writes and raise no violation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 4 | Register select code |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| priv_s | input | 1 | Current privilege: 1 supervisor, 0 user |
| vec_num | input | 8 | Exception vector number |
| fc_sup | input | 1 | Supervisor bit (bit 2) of the access function code |
| rd_data | output | 32 | Registered read data |
| priv_viol | output | 1 | One-cycle privilege violation pulse |
| vec_addr | output | 32 | Exception vector fetch address |
| root_ptr | output | 32 | Selected translation root pointer |
| page_8k | output | 1 | Page size flag from translation control |

## Verification
The hardest cases to reach are a denied user write followed by a supervisor read-back that proves the register did not change, and a read and write to the same register in one cycle, where the old value must come out. The bench produces these with directed sequences that change the privilege between consecutive accesses. A long stretch of random accesses follows, biased toward user mode and toward the mapped select codes. A behavioural model tracks every register and is compared against all outputs on every cycle.

// File: rtl/priv_ctl_pkg.sv
package priv_ctl_pkg;
  localparam int SEL_W   = 4;
  localparam int NUM_TT  = 4;
  localparam int SR_W    = 16;
  localparam int CCR_W   = 8;
  localparam int SFC_W   = 3;
  localparam int TC_EN_BIT = 15;
  localparam int TC_PG_BIT = 14;
  localparam logic [SR_W-1:0] SR_RESET = 16'h2700;

  typedef enum logic [SEL_W-1:0] {
    SEL_SR   = 4'd0,
    SEL_CCR  = 4'd1,
    SEL_VBR  = 4'd2,
    SEL_SFC  = 4'd3,
    SEL_DFC  = 4'd4,
    SEL_URP  = 4'd5,
    SEL_SRP  = 4'd6,
    SEL_TC   = 4'd7,
    SEL_TT0  = 4'd8
  } reg_sel_e;

  localparam logic [SEL_W-1:0] SEL_LAST = SEL_W'(int'(SEL_TT0) + NUM_TT - 1);

  function automatic logic sel_mapped(logic [SEL_W-1:0] s);
    return s <= SEL_LAST;
  endfunction

  function automatic logic sel_open(logic [SEL_W-1:0] s);
    return (s == SEL_SR) || (s == SEL_CCR);
  endfunction

  function automatic logic sel_super_only(logic [SEL_W-1:0] s);
    return sel_mapped(s) && !sel_open(s);
  endfunction
endpackage

// File: rtl/priv_ctl_rst_sync.sv
module priv_ctl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/priv_ctl_access.sv
module priv_ctl_access
  import priv_ctl_pkg::*;
(
  input  logic [SEL_W-1:0] sel_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic             priv_s_i,
  output logic             deny_o,
  output logic             rd_ok_o,
  output logic             wr_ok_o,
  output logic             sys_byte_o
);
  logic blocked;

  always_comb begin
    blocked    = sel_super_only(sel_i) && !priv_s_i;
    deny_o     = (rd_i || wr_i) && blocked;
    rd_ok_o    = rd_i && sel_mapped(sel_i) && !blocked;
    wr_ok_o    = wr_i && sel_mapped(sel_i) && !blocked;
    sys_byte_o = priv_s_i;
  end
endmodule

// File: rtl/priv_ctl_regfile.sv
module priv_ctl_regfile
  import priv_ctl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [SEL_W-1:0]              sel_i,
  input  logic                          wr_ok_i,
  input  logic                          sys_byte_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic [SR_W-1:0]               sr_o,
  output logic [DATA_W-1:0]             vbr_o,
  output logic [SFC_W-1:0]              sfc_o,
  output logic [SFC_W-1:0]              dfc_o,
  output logic [DATA_W-1:0]             urp_o,
  output logic [DATA_W-1:0]             srp_o,
  output logic                          tc_en_o,
  output logic                          tc_pg_o,
  output logic [NUM_TT-1:0][DATA_W-1:0] tt_o
);
  logic [SR_W-1:0]   sr_d;
  logic [DATA_W-1:0] vbr_d, urp_d, srp_d;
  logic [SFC_W-1:0]  sfc_d, dfc_d;
  logic              tc_en_d, tc_pg_d;

  always_comb begin
    sr_d    = sr_o;
    vbr_d   = vbr_o;
    sfc_d   = sfc_o;
    dfc_d   = dfc_o;
    urp_d   = urp_o;
    srp_d   = srp_o;
    tc_en_d = tc_en_o;
    tc_pg_d = tc_pg_o;
    if (wr_ok_i) begin
      case (sel_i)
        SEL_SR: begin
          if (sys_byte_i) sr_d = wdata_i[SR_W-1:0];
          else            sr_d = {sr_o[SR_W-1:CCR_W], wdata_i[CCR_W-1:0]};
        end
        SEL_CCR: sr_d  = {sr_o[SR_W-1:CCR_W], wdata_i[CCR_W-1:0]};
        SEL_VBR: vbr_d = wdata_i;
        SEL_SFC: sfc_d = wdata_i[SFC_W-1:0];
        SEL_DFC: dfc_d = wdata_i[SFC_W-1:0];
        SEL_URP: urp_d = wdata_i;
        SEL_SRP: srp_d = wdata_i;
        SEL_TC: begin
          tc_en_d = wdata_i[TC_EN_BIT];
          tc_pg_d = wdata_i[TC_PG_BIT];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_o    <= SR_RESET;
      vbr_o   <= '0;
      sfc_o   <= '0;
      dfc_o   <= '0;
      urp_o   <= '0;
      srp_o   <= '0;
      tc_en_o <= 1'b0;
      tc_pg_o <= 1'b0;
    end else begin
      sr_o    <= sr_d;
      vbr_o   <= vbr_d;
      sfc_o   <= sfc_d;
      dfc_o   <= dfc_d;
      urp_o   <= urp_d;
      srp_o   <= srp_d;
      tc_en_o <= tc_en_d;
      tc_pg_o <= tc_pg_d;
    end
  end

  for (genvar g = 0; g < NUM_TT; g++) begin : g_tt
    logic [DATA_W-1:0] tt_d;
    logic              tt_we;

    always_comb begin
      tt_we = wr_ok_i && (sel_i == SEL_W'(int'(SEL_TT0) + g));
      tt_d  = tt_we ? wdata_i : tt_o[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tt_o[g] <= '0;
      else        tt_o[g] <= tt_d;
    end
  end
endmodule

// File: rtl/priv_ctl_vector.sv
module priv_ctl_vector #(
  parameter int DATA_W = 32,
  parameter int VEC_W  = 8
) (
  input  logic [DATA_W-1:0] base_i,
  input  logic [VEC_W-1:0]  vec_num_i,
  output logic [DATA_W-1:0] addr_o
);
  localparam int PAD_W = DATA_W - VEC_W - 2;
  logic [DATA_W-1:0] disp;

  always_comb begin
    disp   = {{PAD_W{1'b0}}, vec_num_i, 2'b00};
    addr_o = base_i + disp;
  end
endmodule

// File: rtl/priv_ctl_regs.sv
module priv_ctl_regs
  import priv_ctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              priv_s,
  input  logic [VEC_W-1:0]  vec_num,
  input  logic              fc_sup,
  output logic [DATA_W-1:0] rd_data,
  output logic              priv_viol,
  output logic [DATA_W-1:0] vec_addr,
  output logic [DATA_W-1:0] root_ptr,
  output logic              page_8k
);
  logic                          rst_sync_n;
  logic                          deny, rd_ok, wr_ok, sys_byte;
  logic [SR_W-1:0]               sr_q;
  logic [DATA_W-1:0]             vbr_q, urp_q, srp_q;
  logic [SFC_W-1:0]              sfc_q, dfc_q;
  logic                          tc_en_q, tc_pg_q;
  logic [NUM_TT-1:0][DATA_W-1:0] tt_q;
  logic [DATA_W-1:0]             rd_val, rd_data_d;
  logic                          viol_d;

  priv_ctl_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  priv_ctl_access u_access (
    .sel_i      (reg_sel),
    .rd_i       (rd_en),
    .wr_i       (wr_en),
    .priv_s_i   (priv_s),
    .deny_o     (deny),
    .rd_ok_o    (rd_ok),
    .wr_ok_o    (wr_ok),
    .sys_byte_o (sys_byte)
  );

  priv_ctl_regfile #(.DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .sel_i      (reg_sel),
    .wr_ok_i    (wr_ok),
    .sys_byte_i (sys_byte),
    .wdata_i    (wr_data),
    .sr_o       (sr_q),
    .vbr_o      (vbr_q),
    .sfc_o      (sfc_q),
    .dfc_o      (dfc_q),
    .urp_o      (urp_q),
    .srp_o      (srp_q),
    .tc_en_o    (tc_en_q),
    .tc_pg_o    (tc_pg_q),
    .tt_o       (tt_q)
  );

  priv_ctl_vector #(.DATA_W(DATA_W), .VEC_W(VEC_W)) u_vec (
    .base_i    (vbr_q),
    .vec_num_i (vec_num),
    .addr_o    (vec_addr)
  );

  always_comb begin
    rd_val = '0;
    case (reg_sel)
      SEL_SR: begin
        if (sys_byte) rd_val = DATA_W'(sr_q);
        else          rd_val = DATA_W'(sr_q[CCR_W-1:0]);
      end
      SEL_CCR: rd_val = DATA_W'(sr_q[CCR_W-1:0]);
      SEL_VBR: rd_val = vbr_q;
      SEL_SFC: rd_val = DATA_W'(sfc_q);
      SEL_DFC: rd_val = DATA_W'(dfc_q);
      SEL_URP: rd_val = urp_q;
      SEL_SRP: rd_val = srp_q;
      SEL_TC:  rd_val = DATA_W'({tc_en_q, tc_pg_q}) << TC_PG_BIT;
      default: begin
        for (int i = 0; i < NUM_TT; i++) begin
          if (reg_sel == SEL_W'(int'(SEL_TT0) + i)) rd_val = tt_q[i];
        end
      end
    endcase
  end

  always_comb begin
    rd_data_d = rd_data;
    if (rd_en) rd_data_d = rd_ok ? rd_val : '0;
    viol_d    = deny;
    root_ptr  = fc_sup ? srp_q : urp_q;
    page_8k   = tc_pg_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rd_data   <= '0;
      priv_viol <= 1'b0;
    end else begin
      rd_data   <= rd_data_d;
      priv_viol <= viol_d;
    end
  end
endmodule

// File: rtl/priv_ctl_checker.sv
module priv_ctl_checker
  import priv_ctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int VEC_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SEL_W-1:0]  reg_sel,
  input logic              rd_en,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              priv_s,
  input logic [VEC_W-1:0]  vec_num,
  input logic              fc_sup,
  input logic [DATA_W-1:0] rd_data,
  input logic              priv_viol,
  input logic [DATA_W-1:0] vec_addr,
  input logic [DATA_W-1:0] root_ptr,
  input logic [SR_W-1:0]   sr_val,
  input logic [DATA_W-1:0] vbr_val
);
  a_r4_deny_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en || wr_en) && !priv_s && sel_super_only(reg_sel) |=> priv_viol);

  a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    priv_viol |-> $past((rd_en || wr_en) && !priv_s && sel_super_only(reg_sel)));

  a_r2_sys_byte_kept: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !priv_s && (reg_sel == SEL_SR)
    |=> sr_val[SR_W-1:CCR_W] == $past(sr_val[SR_W-1:CCR_W]));

  a_r1_ccr_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (reg_sel == SEL_CCR) |=> sr_val[CCR_W-1:0] == $past(wr_data[CCR_W-1:0]));

  a_r3_vbr_kept: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !priv_s && (reg_sel == SEL_VBR) |=> $stable(vbr_val));

  a_r3_denied_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !priv_s && sel_super_only(reg_sel) |=> rd_data == '0);

  a_r5_vec_step: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(vbr_val) && ($past(vec_num) != '1) && (vec_num == VEC_W'($past(vec_num) + 1'b1))
    |-> vec_addr == $past(vec_addr) + DATA_W'(4));

  a_r6_user_root: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && priv_s && (reg_sel == SEL_URP) ##1 !fc_sup |-> root_ptr == $past(wr_data));
endmodule

bind priv_ctl_regs priv_ctl_checker #(.DATA_W(DATA_W), .VEC_W(VEC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .reg_sel   (reg_sel),
  .rd_en     (rd_en),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .priv_s    (priv_s),
  .vec_num   (vec_num),
  .fc_sup    (fc_sup),
  .rd_data   (rd_data),
  .priv_viol (priv_viol),
  .vec_addr  (vec_addr),
  .root_ptr  (root_ptr),
  .sr_val    (sr_q),
  .vbr_val   (vbr_q)
);

// File: tb/priv_ctl_regs_bench.sv
`timescale 1ns/1ps
module priv_ctl_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  reg_sel;
  logic        rd_en, wr_en, priv_s, fc_sup;
  logic [31:0] wr_data;
  logic [7:0]  vec_num;
  logic [31:0] rd_data, vec_addr, root_ptr;
  logic        priv_viol, page_8k;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  priv_ctl_regs u_priv_ctl_regs (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .priv_s(priv_s), .vec_num(vec_num), .fc_sup(fc_sup),
    .rd_data(rd_data), .priv_viol(priv_viol), .vec_addr(vec_addr),
    .root_ptr(root_ptr), .page_8k(page_8k)
  );

  // behavioural model state
  logic [15:0] m_sr;
  logic [31:0] m_vbr, m_urp, m_srp, m_tc, m_sfc, m_dfc;
  logic [31:0] m_tt [4];
  logic [31:0] m_rd;
  logic        m_viol;
  string       m_tag = "R9";

  function automatic bit guarded(input logic [3:0] s);
    return (s >= 4'd2) && (s <= 4'd11);
  endfunction

  function automatic logic [31:0] peek(input logic [3:0] s, input logic sup);
    case (s)
      4'd0: return sup ? {16'h0, m_sr} : {24'h0, m_sr[7:0]};
      4'd1: return {24'h0, m_sr[7:0]};
      4'd2: return m_vbr;
      4'd3: return m_sfc;
      4'd4: return m_dfc;
      4'd5: return m_urp;
      4'd6: return m_srp;
      4'd7: return m_tc;
      4'd8, 4'd9, 4'd10, 4'd11: return m_tt[s - 4'd8];
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_for(input logic [3:0] s, input logic sup);
    if (s == 4'd0 && !sup)          return "R2";
    if (s <= 4'd1)                  return "R1";
    if (guarded(s) && !sup)         return "R3";
    if (s == 4'd3 || s == 4'd4)     return "R7";
    if (s == 4'd7)                  return "R8";
    return "R10";
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sr = 16'h2700; m_vbr = 0; m_urp = 0; m_srp = 0; m_tc = 0; m_sfc = 0; m_dfc = 0;
      foreach (m_tt[i]) m_tt[i] = 0;
      m_rd = 0; m_viol = 0;
    end else begin
      if (rd_en) begin
        m_rd  = (guarded(reg_sel) && !priv_s) ? 32'h0 : peek(reg_sel, priv_s);
        m_tag = tag_for(reg_sel, priv_s);
      end
      m_viol = (rd_en || wr_en) && !priv_s && guarded(reg_sel);
      if (wr_en && !(guarded(reg_sel) && !priv_s)) begin
        case (reg_sel)
          4'd0: m_sr = priv_s ? wr_data[15:0] : {m_sr[15:8], wr_data[7:0]};
          4'd1: m_sr = {m_sr[15:8], wr_data[7:0]};
          4'd2: m_vbr = wr_data;
          4'd3: m_sfc = wr_data & 32'h7;
          4'd4: m_dfc = wr_data & 32'h7;
          4'd5: m_urp = wr_data;
          4'd6: m_srp = wr_data;
          4'd7: m_tc  = wr_data & 32'hC000;
          4'd8, 4'd9, 4'd10, 4'd11: m_tt[reg_sel - 4'd8] = wr_data;
          default: ;
        endcase
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check(m_tag, rd_data, m_rd);
    check("R4", {31'h0, priv_viol}, {31'h0, m_viol});
    check("R5", vec_addr, m_vbr + {22'h0, vec_num, 2'b00});
    check("R6", root_ptr, fc_sup ? m_srp : m_urp);
    check("R8", {31'h0, page_8k}, {31'h0, m_tc[14]});
  endtask

  task automatic step(input logic [3:0] s, input bit rd, input bit wr,
                      input logic [31:0] d, input bit sup);
    @(negedge clk);
    compare_all();
    reg_sel = s; rd_en = rd; wr_en = wr; wr_data = d; priv_s = sup;
  endtask

  task automatic idle();
    step(4'd15, 1'b0, 1'b0, 32'h0, 1'b1);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_sel = 4'd15; rd_en = 0; wr_en = 0; wr_data = 0;
    priv_s = 1; vec_num = 0; fc_sup = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) idle();

    // R9: reset values at the ports and through reads
    check("R9", rd_data, 32'h0);
    check("R9", {31'h0, priv_viol}, 32'h0);
    check("R9", vec_addr, 32'h0);
    check("R9", {31'h0, page_8k}, 32'h0);
    step(4'd0, 1, 0, 0, 1); idle(); check("R9", rd_data, 32'h0000_2700);
    step(4'd7, 1, 0, 0, 1); idle(); check("R9", rd_data, 32'h0);
    step(4'd2, 1, 0, 0, 1); idle(); check("R9", rd_data, 32'h0);

    // R7: function-code width
    step(4'd3, 0, 1, 32'hFFFF_FFFD, 1); step(4'd3, 1, 0, 0, 1); idle();
    check("R7", rd_data, 32'h5);
    // R8: translation control fields
    step(4'd7, 0, 1, 32'hFFFF_FFFF, 1); step(4'd7, 1, 0, 0, 1); idle();
    check("R8", rd_data, 32'h0000_C000);
    check("R8", {31'h0, page_8k}, 32'h1);
    // R5: vector address
    step(4'd2, 0, 1, 32'h0000_1000, 1); vec_num = 8'h40; idle();
    check("R5", vec_addr, 32'h0000_1100);
    // R6: root pointer selection
    step(4'd5, 0, 1, 32'hAAAA_0000, 1); step(4'd6, 0, 1, 32'h5555_0000, 1);
    fc_sup = 0; idle(); check("R6", root_ptr, 32'hAAAA_0000);
    fc_sup = 1; idle(); check("R6", root_ptr, 32'h5555_0000);
    // R3 and R4: denied write then supervisor read-back
    step(4'd2, 0, 1, 32'hDEAD_BEEF, 0); idle();
    check("R4", {31'h0, priv_viol}, 32'h1);
    step(4'd2, 1, 0, 0, 1); idle();
    check("R3", rd_data, 32'h0000_1000);
    check("R4", {31'h0, priv_viol}, 32'h0);
    step(4'd6, 1, 0, 0, 0); idle(); check("R3", rd_data, 32'h0);
    // R2: user write to full status word
    step(4'd0, 0, 1, 32'h0000_00FF, 0); step(4'd0, 1, 0, 0, 1); idle();
    check("R2", rd_data, 32'h0000_27FF);
    step(4'd0, 1, 0, 0, 0); idle(); check("R2", rd_data, 32'h0000_00FF);
    // R1: condition-code byte from user mode
    step(4'd1, 0, 1, 32'hFFFF_FF1F, 0); step(4'd1, 1, 0, 0, 0); idle();
    check("R1", rd_data, 32'h0000_001F);
    // R10: read and write together return the old value; unmapped codes
    step(4'd2, 1, 1, 32'h0000_2000, 1); idle(); check("R10", rd_data, 32'h0000_1000);
    step(4'd13, 1, 1, 32'h1234_5678, 0); idle();
    check("R10", rd_data, 32'h0);
    check("R10", {31'h0, priv_viol}, 32'h0);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] s;
      s = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(12, 15)) : 4'($urandom_range(0, 11));
      vec_num = 8'($urandom);
      fc_sup  = 1'($urandom);
      step(s, 1'($urandom), 1'($urandom), $urandom, $urandom_range(0, 2) == 0);
    end
    idle(); idle();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule